// File: doc/BRIEF.md
# Serial Port Status Flag Logic

This block keeps the status flags of an asynchronous serial port that supports a multiprocessor bit. The receiver and transmitter report their progress to it through single-cycle strobes: a character finished (with a parity-error qualifier and the received multiprocessor bit), the transmit data register moved into the shifter, the last bit shifted out, and a DMA write into the transmit data register. The block turns these strobes into flags that the CPU reads through an 8-bit status register. It also produces the inhibit signals that stop the receiver, and in clocked synchronous mode the transmitter, while a parity error is pending.

Software clears a flag with two steps. It must first read the status register while that flag is 1, and then write a 0 to the flag's bit. A read that sees a flag at 1 arms that flag, and the next write to the register consumes the arm. When a hardware event sets a flag in the same cycle as a CPU clear, the hardware event takes priority.

Status register bits: bit 0 `mpbt` (read/write), bit 1 `mpb` (read-only), bit 2 `tx_end` (read-only), bit 3 `per` (read, write 0 to clear), bit 4 `rx_full` (read, write 0 to clear), bit 5 `tx_empty` (read, write 0 to clear), bits 7:6 read 0.

Top module: `ser_stat_flags`

## Requirements
- R1: After reset, `cpu_rdata` reads 8'h24. This means `tx_empty`=1, `tx_end`=1, and `per_flag`, `rx_full`, `mpb`, `tx_mpb` are all 0.
- R2: A character is accepted when `rx_done` is high, `rx_en`=1 and `per_flag`=0. In that cycle `rdr_load` pulses. If `rx_perr` is 1, `per_flag` is set on the next cycle and `rx_full` is left unchanged. Otherwise `rx_full` is set.
- R3: While `per_flag`=1, `rx_block`=1 and `rx_done` is ignored: `rdr_load` stays 0, and `rx_full` and `mpb` do not change. `tx_block` is 1 only while `per_flag`=1 and `sync_mode`=1.
- R4: Writing 0 to bit 3, 4 or 5 clears that flag only if a read since the previous write returned the flag as 1. Writing 1 has no effect. Any write consumes the arm.
- R5: If a hardware set of `rx_full`, `tx_empty` or `tx_end` happens in the same cycle as a CPU clear of that flag, the flag stays 1.
- R6: When `rx_en`=0, `rx_done` is ignored, and `per_flag` and `mpb` keep their values.
- R7: While `tx_en`=0, `tx_end` is 1 from the next cycle on.
- R8: A `tx_last` strobe sets `tx_end` if `tx_empty` is 1 in that cycle. If `tx_empty` is 0, `tx_end` is left unchanged.
- R9: Clearing `tx_empty` through the R4 handshake also clears `tx_end`. A `dma_wr` strobe clears both `tx_empty` and `tx_end`.
- R10: `mpb` captures `rx_mpb` on each accepted character. Writes to bit 0 set `tx_mpb`, and bit 0 reads it back. Writes to bits 1 and 2 have no effect.
- R11: A `tx_load` strobe sets `tx_empty`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_en | input | 1 | Receive enable |
| tx_en | input | 1 | Transmit enable |
| sync_mode | input | 1 | Clocked synchronous mode selected |
| rx_done | input | 1 | Receiver finished a character |
| rx_perr | input | 1 | Parity error on that character |
| rx_mpb | input | 1 | Received multiprocessor bit |
| tx_load | input | 1 | Transmit data moved into the shifter |
| tx_last | input | 1 | Last bit of a character shifted out |
| dma_wr | input | 1 | DMA wrote the transmit data register |
| cpu_rd | input | 1 | CPU read of the status register |
| cpu_wr | input | 1 | CPU write of the status register |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rdata | output | 8 | Status register contents |
| per_flag | output | 1 | Parity error flag |
| rx_full | output | 1 | Receive data full flag |
| tx_empty | output | 1 | Transmit data empty flag |
| tx_end | output | 1 | Transmit end flag |
| mpb | output | 1 | Received multiprocessor bit |
| tx_mpb | output | 1 | Multiprocessor bit to transmit |
| rdr_load | output | 1 | Load received byte into the data register |
| rx_block | output | 1 | Receive inhibit |
| tx_block | output | 1 | Transmit inhibit |

## Verification
The block has no parameters, so the bench builds it as it is. Its state is small enough to sweep every combination of the relevant inputs. The bench steps through receive enable, parity qualifier and multiprocessor bit for every receive event. For the clear handshake it tries each of read-first or write-only with write values 0 and 1. It also covers the transmit-end rule both with and without the data-empty flag set. The same-cycle collisions between a set and a clear, and the synchronous-mode transmit inhibit, are driven directly.

// File: rtl/ser_stat_flags.sv
module ser_stat_flags (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_en,
  input  logic       tx_en,
  input  logic       sync_mode,
  input  logic       rx_done,
  input  logic       rx_perr,
  input  logic       rx_mpb,
  input  logic       tx_load,
  input  logic       tx_last,
  input  logic       dma_wr,
  input  logic       cpu_rd,
  input  logic       cpu_wr,
  input  logic [7:0] cpu_wdata,
  output logic [7:0] cpu_rdata,
  output logic       per_flag,
  output logic       rx_full,
  output logic       tx_empty,
  output logic       tx_end,
  output logic       mpb,
  output logic       tx_mpb,
  output logic       rdr_load,
  output logic       rx_block,
  output logic       tx_block
);

  logic per_q, rdrf_q, tdre_q, tend_q, mpb_q, mpbt_q;
  logic arm_per, arm_rdrf, arm_tdre;

  wire accept   = rx_done & rx_en & ~per_q;
  wire clr_per  = cpu_wr & arm_per  & ~cpu_wdata[3];
  wire clr_rdrf = cpu_wr & arm_rdrf & ~cpu_wdata[4];
  wire clr_tdre = cpu_wr & arm_tdre & ~cpu_wdata[5];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arm_per  <= 1'b0;
      arm_rdrf <= 1'b0;
      arm_tdre <= 1'b0;
    end else if (cpu_wr) begin
      arm_per  <= 1'b0;
      arm_rdrf <= 1'b0;
      arm_tdre <= 1'b0;
    end else if (cpu_rd) begin
      arm_per  <= arm_per  | per_q;
      arm_rdrf <= arm_rdrf | rdrf_q;
      arm_tdre <= arm_tdre | tdre_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_q  <= 1'b0;
      rdrf_q <= 1'b0;
      tdre_q <= 1'b1;
      tend_q <= 1'b1;
      mpb_q  <= 1'b0;
      mpbt_q <= 1'b0;
    end else begin
      if (accept & rx_perr)       per_q <= 1'b1;
      else if (clr_per)           per_q <= 1'b0;

      if (accept & ~rx_perr)      rdrf_q <= 1'b1;
      else if (clr_rdrf)          rdrf_q <= 1'b0;

      if (accept)                 mpb_q <= rx_mpb;

      if (tx_load)                tdre_q <= 1'b1;
      else if (clr_tdre | dma_wr) tdre_q <= 1'b0;

      if (~tx_en | (tx_last & tdre_q)) tend_q <= 1'b1;
      else if (clr_tdre | dma_wr)      tend_q <= 1'b0;

      if (cpu_wr)                 mpbt_q <= cpu_wdata[0];
    end
  end

  assign cpu_rdata = {2'b00, tdre_q, rdrf_q, per_q, tend_q, mpb_q, mpbt_q};
  assign per_flag  = per_q;
  assign rx_full   = rdrf_q;
  assign tx_empty  = tdre_q;
  assign tx_end    = tend_q;
  assign mpb       = mpb_q;
  assign tx_mpb    = mpbt_q;
  assign rdr_load  = accept;
  assign rx_block  = per_q;
  assign tx_block  = per_q & sync_mode;

endmodule

module ser_stat_flags_chk (
  input logic clk,
  input logic rst_n,
  input logic rx_en,
  input logic tx_en,
  input logic rx_done,
  input logic rx_perr,
  input logic tx_load,
  input logic tx_last,
  input logic dma_wr,
  input logic cpu_wr,
  input logic per_flag,
  input logic tx_empty,
  input logic tx_end,
  input logic rdr_load
);
  AST_PERR_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done && rx_en && !per_flag && rx_perr |=> per_flag); // R2
  AST_BLOCKED_NO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    per_flag |-> !rdr_load); // R3
  AST_PER_CLR_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(per_flag) |-> $past(cpu_wr)); // R4
  AST_TX_OFF_END: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |=> tx_end); // R7
  AST_LAST_END: assert property (@(posedge clk) disable iff (!rst_n)
    tx_last && tx_empty |=> tx_end); // R8
  AST_DMA_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    dma_wr && !tx_load |=> !tx_empty); // R9
  AST_LOAD_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    tx_load |=> tx_empty); // R11
endmodule

bind ser_stat_flags ser_stat_flags_chk u_chk (.*);

// File: tb/ser_stat_flags_tb.sv
module ser_stat_flags_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic rx_en = 0, tx_en = 0, sync_mode = 0, rx_done = 0, rx_perr = 0, rx_mpb = 0;
  logic tx_load = 0, tx_last = 0, dma_wr = 0, cpu_rd = 0, cpu_wr = 0;
  logic [7:0] cpu_wdata = 8'h00;
  logic [7:0] cpu_rdata;
  logic per_flag, rx_full, tx_empty, tx_end, mpb, tx_mpb, rdr_load, rx_block, tx_block;
  int checks = 0, errors = 0;
  logic [7:0] v;
  logic mpb_exp;

  always #10 clk = ~clk;

  ser_stat_flags u_dut (.*);

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rd(output logic [7:0] d);
    @(negedge clk) cpu_rd = 1;
    #1 d = cpu_rdata;
    @(negedge clk) cpu_rd = 0;
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk) begin cpu_wr = 1; cpu_wdata = d; end
    @(negedge clk) begin cpu_wr = 0; cpu_wdata = 8'h00; end
  endtask

  task automatic rxev(input logic p, input logic m, output logic ld);
    @(negedge clk) begin rx_done = 1; rx_perr = p; rx_mpb = m; end
    #1 ld = rdr_load;
    @(negedge clk) begin rx_done = 0; rx_perr = 0; rx_mpb = 0; end
  endtask

  task automatic pulse_load(); @(negedge clk) tx_load = 1; @(negedge clk) tx_load = 0; endtask
  task automatic pulse_last(); @(negedge clk) tx_last = 1; @(negedge clk) tx_last = 0; endtask
  task automatic pulse_dma();  @(negedge clk) dma_wr = 1;  @(negedge clk) dma_wr = 0;  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic ld;
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 rdata", cpu_rdata, 8'h24);
    chk("R1 flags", {per_flag, rx_full, tx_empty, tx_end, mpb, tx_mpb}, 8'b001100);
    mpb_exp = 0;

    tx_en = 1;
    pulse_dma();
    chk("R9 dma clears", {tx_empty, tx_end}, 8'b00);
    @(negedge clk) tx_en = 0;
    @(negedge clk) tx_en = 1;
    chk("R7 disable sets end", tx_end, 1);

    for (int te = 0; te < 2; te++) begin
      pulse_dma();
      if (te == 1) begin pulse_load(); chk("R11 load sets empty", tx_empty, 1); end
      pulse_last();
      chk("R8 last bit end", tx_end, 8'(te));
    end

    for (int rf = 0; rf < 2; rf++)
      for (int wb = 0; wb < 2; wb++) begin
        pulse_dma(); pulse_load(); pulse_last();
        if (rf == 1) rd(v);
        wr(wb ? 8'h20 : 8'h00);
        chk("R4 tdre handshake", tx_empty, (rf == 1 && wb == 0) ? 0 : 1);
        chk("R9 tend with tdre clear", tx_end, (rf == 1 && wb == 0) ? 0 : 1);
        if (rf == 1 && wb == 1) begin
          wr(8'h00);
          chk("R4 arm consumed", tx_empty, 1);
        end
      end

    rx_en = 0;
    for (int en = 0; en < 2; en++)
      for (int p = 0; p < 2; p++)
        for (int m = 0; m < 2; m++) begin
          rx_en = en[0];
          rxev(p[0], m[0], ld);
          chk("R2 load strobe", ld, 8'(en));
          chk("R2 per", per_flag, 8'(en & p));
          chk("R2 rx_full", rx_full, 8'(en & ~p & 1));
          if (en == 1) mpb_exp = m[0];
          chk("R10 mpb capture", mpb, mpb_exp);
          if (en == 0) chk("R6 rx off ignored", {per_flag, rx_full}, 8'b00);
          rd(v);
          wr(8'h20);
          chk("R4 clear rx flags", {per_flag, rx_full}, 8'b00);
        end

    rx_en = 1;
    rxev(1'b1, 1'b1, ld);
    mpb_exp = 1;
    sync_mode = 0; #1;
    chk("R3 rx_block", rx_block, 1);
    chk("R3 tx_block async", tx_block, 0);
    sync_mode = 1; #1;
    chk("R3 tx_block sync", tx_block, 1);
    sync_mode = 0;
    rxev(1'b0, 1'b0, ld);
    chk("R3 blocked no load", ld, 0);
    chk("R3 blocked flags", {rx_full, mpb}, 8'b01);
    rx_en = 0;
    repeat (2) @(negedge clk);
    chk("R6 per and mpb kept", {per_flag, mpb}, 8'b11);
    rx_en = 1;

    wr(8'h00);
    chk("R4 no read no clear", per_flag, 1);
    rd(v);
    wr(8'h08);
    chk("R4 write one no effect", per_flag, 1);
    rd(v);
    wr(8'h00);
    chk("R4 read then zero clears", per_flag, 0);

    rxev(1'b0, 1'b0, ld);
    rd(v);
    @(negedge clk) begin cpu_wr = 1; cpu_wdata = 8'h00; rx_done = 1; end
    @(negedge clk) begin cpu_wr = 0; rx_done = 0; end
    chk("R5 rx_full set wins", rx_full, 1);
    pulse_load();
    rd(v);
    @(negedge clk) begin cpu_wr = 1; cpu_wdata = 8'h00; tx_load = 1; tx_last = 1; end
    @(negedge clk) begin cpu_wr = 0; tx_load = 0; tx_last = 0; end
    chk("R5 tdre and tend set win", {tx_empty, tx_end}, 8'b11);

    wr(8'h21);
    chk("R10 mpbt", {tx_mpb, cpu_rdata[0]}, 8'b11);
    wr(8'h20);
    chk("R10 mpbt low", tx_mpb, 0);
    pulse_dma();
    rxev(1'b0, 1'b0, ld);
    chk("R10 mpb setup", mpb, 0);
    wr(8'h26);
    chk("R10 ro bits ignore write", {mpb, tx_end}, 8'b00);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule